// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This cell is the repeating logic element of a small programmable fabric. It holds two function tables, each eight words deep and two bits wide. The same three logic inputs address both tables, with `lg_in[2]` as the most significant address bit. The two bits of one word give two independent Boolean functions of those three inputs, so the cell offers four function outputs in all. Each function output has a flip-flop and a 2-to-1 selector. One configuration bit per output picks either the registered value or the raw table bit.

A single-word write port loads configuration while the fabric is being set up. Through it, software writes table words and the per-output select bits. Configuration is treated as static once the logic runs. Reset clears only the output flip-flops and leaves configuration alone. The cell has no streaming data path, so every pin is a plain level signal with no handshake.

For sequential use, the surrounding routing feeds registered outputs back onto the logic inputs. For example, two registered outputs fed back to `lg_in[1:0]` give a 2-bit state machine. An input that a function does not need is tied to 0, which leaves the upper half of the table unused.

Top module: `lut_logic_cell`

## Requirements
- R1: A configuration write with `cfg_addr[4]`=0 stores `cfg_data` into word `cfg_addr[2:0]` of table `cfg_addr[3]` on the rising clock edge. The stored word is readable from the next cycle.
- R2: When an output's select bit is 0, that output is combinational. `lg_out[2*t+k]` equals bit k of word `lg_in` (with `lg_in[2]` as MSB) of table t, with no clock delay.
- R3: When an output's select bit is 1, that output shows the table bit that was addressed at the previous rising edge. A change of `lg_in` between edges does not reach it.
- R4: Synchronous active-high `rst` clears all four output flip-flops on the rising edge. It does not change table contents or select bits.
- R5: The two bits of one table and the two tables are independent functions. A write to one table leaves the other table's outputs unchanged.
- R6: A configuration write with `cfg_addr[4]`=1 stores `cfg_data[k]` as the select bit of output `2*cfg_addr[3]+k`. Address bits 2..0 are ignored for such writes. Each output's select is independent.
- R7: With `cfg_we` low, activity on `cfg_addr` and `cfg_data` changes no configuration.
- R8: With two registered outputs fed back to the address inputs, the cell steps through a state sequence held in its flip-flops.
- R9: With `lg_in[2]` tied to 0, the contents of words 4 to 7 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of output flip-flops |
| lg_in | input | 3 | Logic inputs, table address (bit 2 MSB) |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration address {kind, table, word} |
| cfg_data | input | 2 | Configuration write data |
| lg_out | output | 4 | Function outputs, index 2*table+bit |

## Verification
The embedded assertions check on every cycle that:
- table and select writes land at the decoded location;
- a cycle without a write leaves a table untouched;
- each flip-flop carries the table bit it saw one edge earlier;
- reset leaves the flip-flops at zero.

Only the directed scenarios can show:
- the full input-to-output mapping across all eight addresses;
- the per-output mix of registered and direct paths;
- configuration surviving a reset;
- the fed-back state sequence that ignores the upper half of the table.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
  localparam int unsigned TBL_IN_W  = 3;
  localparam int unsigned TBL_OUT_W = 2;
  localparam int unsigned TBL_COUNT = 2;

  typedef enum logic {
    CFG_TABLE  = 1'b0,
    CFG_SELECT = 1'b1
  } cfg_kind_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned IN_W  = 3,
  parameter int unsigned OUT_W = 2,
  localparam int unsigned DEPTH = 1 << IN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  wr_word,
  input  logic [OUT_W-1:0] wr_val,
  input  logic [IN_W-1:0]  rd_word,
  output logic [OUT_W-1:0] rd_val
);
  logic [DEPTH-1:0][OUT_W-1:0] words;

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_word] <= wr_val;
  end

  assign rd_val = words[rd_word];

  assert_table_write_R1: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> words[$past(wr_word)] == $past(wr_val));

  assert_table_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(words));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] use_reg,
  output logic [W-1:0] y
);
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= raw;
  end

  for (genvar b = 0; b < W; b++) begin : g_pick
    assign y[b] = use_reg[b] ? held[b] : raw[b];
  end

  assert_reset_clears_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> held == '0);

  assert_reg_follows_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> held == $past(raw));
endmodule

// File: rtl/lut_logic_cell.sv
module lut_logic_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned IN_W  = TBL_IN_W,
  parameter int unsigned OUT_W = TBL_OUT_W,
  parameter int unsigned N_TBL = TBL_COUNT,
  localparam int unsigned TSEL_W = idx_width(N_TBL),
  localparam int unsigned CFG_AW = 1 + TSEL_W + IN_W,
  localparam int unsigned OUT_N  = N_TBL * OUT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   lg_in,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [OUT_W-1:0]  cfg_data,
  output logic [OUT_N-1:0]  lg_out
);
  cfg_kind_e                    kind;
  logic [TSEL_W-1:0]            tsel;
  logic [IN_W-1:0]              word;
  logic [N_TBL-1:0][OUT_W-1:0]  sel_q;

  assign kind = cfg_kind_e'(cfg_addr[CFG_AW-1]);
  assign tsel = cfg_addr[IN_W +: TSEL_W];
  assign word = cfg_addr[IN_W-1:0];

  always_ff @(posedge clk) begin
    if (cfg_we && kind == CFG_SELECT) sel_q[tsel] <= cfg_data;
  end

  for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
    logic [OUT_W-1:0] raw;
    logic             hit;

    assign hit = cfg_we && (kind == CFG_TABLE) && (tsel == TSEL_W'(t));

    lut_table #(.IN_W(IN_W), .OUT_W(OUT_W)) u_tbl (
      .clk(clk), .rst(rst), .wr_en(hit), .wr_word(word), .wr_val(cfg_data),
      .rd_word(lg_in), .rd_val(raw)
    );

    out_stage #(.W(OUT_W)) u_out (
      .clk(clk), .rst(rst), .raw(raw), .use_reg(sel_q[t]),
      .y(lg_out[t*OUT_W +: OUT_W])
    );
  end

  assert_select_write_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && kind == CFG_SELECT) |=> sel_q[$past(tsel)] == $past(cfg_data));

  assert_select_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(sel_q));
endmodule

// File: tb/sim_lut_logic_cell.sv
module sim_lut_logic_cell;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] in_drv = '0;
  logic       fb_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [1:0] cfg_data = '0;
  logic [3:0] lg_out;
  logic [2:0] lg_in;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [1:0] m_tbl [2][8];

  always #2.5 clk = ~clk;

  assign lg_in = fb_mode ? {1'b0, lg_out[1:0]} : in_drv;

  lut_logic_cell u0 (
    .clk(clk), .rst(rst), .lg_in(lg_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .lg_out(lg_out)
  );

  function automatic logic [3:0] model(input logic [2:0] a);
    return {m_tbl[1][a], m_tbl[0][a]};
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_tbl(input int t, input logic [15:0] img);
    for (int w = 0; w < 8; w++) begin
      wr({1'b0, t[0], w[2:0]}, img[2*w +: 2]);
      m_tbl[t][w] = img[2*w +: 2];
    end
  endtask

  task automatic set_sel(input logic [1:0] s0, input logic [1:0] s1);
    wr(5'b10000, s0);
    wr(5'b11101, s1);
  endtask

  // R4: flip-flops cleared while reset is held, config loaded during reset
  task automatic t_reset;
    load_tbl(0, 16'hE41B);
    load_tbl(1, 16'h9C63);
    set_sel(2'b11, 2'b11);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); in_drv = a[2:0];
      @(negedge clk); chk("R4 reset state", lg_out, 4'b0000);
    end
    rst = 1'b0;
  endtask

  // R1 R2 R5: direct outputs, all addresses, two table images
  task automatic t_comb;
    set_sel(2'b00, 2'b00);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); in_drv = a[2:0]; #1;
      chk("R2 direct path", lg_out, model(a[2:0]));
    end
    load_tbl(1, 16'h5A0F);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); in_drv = a[2:0]; #1;
      chk("R1 R5 table rewrite", lg_out, model(a[2:0]));
    end
  endtask

  // R3: registered outputs lag one edge, ignore mid-cycle input change
  task automatic t_reg;
    logic [2:0] prev;
    set_sel(2'b11, 2'b11);
    @(negedge clk); in_drv = 3'd0; prev = 3'd0;
    for (int a = 1; a < 8; a++) begin
      @(negedge clk);
      chk("R3 registered value", lg_out, model(prev));
      in_drv = a[2:0]; #1;
      chk("R3 holds between edges", lg_out, model(prev));
      prev = a[2:0];
    end
  endtask

  // R6: mixed per-output select
  task automatic t_mixed;
    logic [3:0] e;
    set_sel(2'b01, 2'b10);
    @(negedge clk); in_drv = 3'd6;
    @(negedge clk); in_drv = 3'd3; #1;
    e = model(3'd3);
    e[0] = model(3'd6)[0];
    e[3] = model(3'd6)[3];
    chk("R6 mixed select", lg_out, e);
  endtask

  // R7: address/data activity without write enable
  task automatic t_ignored;
    set_sel(2'b00, 2'b00);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); cfg_addr = i[4:0] ^ 5'b10101; cfg_data = i[1:0];
    end
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); in_drv = a[2:0]; #1;
      chk("R7 no write without enable", lg_out, model(a[2:0]));
    end
  endtask

  // R4: reset keeps configuration
  task automatic t_reset_keep;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); in_drv = a[2:0]; #1;
      chk("R4 config survives reset", lg_out, model(a[2:0]));
    end
  endtask

  // R8 R9: 2-bit counter through feedback, upper half unused
  task automatic t_fsm;
    logic [3:0] exp;
    load_tbl(0, 16'h5F39);
    set_sel(2'b11, 2'b00);
    fb_mode = 1'b1;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 counter start", {2'b00, lg_out[1:0]}, 4'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      exp = 4'((i + 1) % 4);
      chk("R8 counter step", {2'b00, lg_out[1:0]}, exp);
    end
    for (int w = 4; w < 8; w++) wr({2'b00, w[2:0]}, 2'(w + 1));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      exp = 4'((i + 1) % 4);
      chk("R9 upper words unused", {2'b00, lg_out[1:0]}, exp);
    end
    fb_mode = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_comb();
    t_reg();
    t_mixed();
    t_ignored();
    t_reset_keep();
    t_fsm();
    finish_run();
  end
endmodule